// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry-Out

This block shifts the second ALU operand by an amount taken from a register, and it produces the carry flag that a flag-setting instruction would write. It supports four shift kinds: logical left, logical right, arithmetic right and rotate right. Only the low eight bits of the amount register count. Amounts of zero, exactly the data width, and greater than the data width each follow their own rule for the result and for the carry.

The operand comes with a flag that marks it as the program counter. When the flag is set, the operand is increased by four before the shift. A decode stage sorts the effective amount into classes and passes strobes to a shift datapath. The top module registers the result and the carry, so both appear one clock after the inputs are presented.

Top module: `barrel_shift_top`

## Requirements
- R1: Only bits 7:0 of `amountReg` set the shift amount. Bits 31:8 have no effect on the result or on the carry.
- R2: An effective amount of zero gives the (possibly adjusted) operand unchanged, and the carry-out equals `carryIn`, for every shift kind.
- R3: Kind 2'b00 (logical left) by 1 to 31 shifts left and fills with zeros. The carry-out is operand bit (32 − amount).
- R4: Logical left by exactly 32 gives zero, and the carry-out is operand bit 0. Any amount above 32 gives zero with a carry-out of 0.
- R5: Kind 2'b01 (logical right) by 1 to 31 shifts right and fills with zeros. The carry-out is operand bit (amount − 1).
- R6: Logical right by exactly 32 gives zero, and the carry-out is operand bit 31. Any amount above 32 gives zero with a carry-out of 0.
- R7: Kind 2'b10 (arithmetic right) by 1 to 31 shifts right and fills with operand bit 31. The carry-out is operand bit (amount − 1).
- R8: Arithmetic right by 32 or more sets every result bit to operand bit 31, and the carry-out is also operand bit 31.
- R9: Kind 2'b11 (rotate right) rotates by the low five bits of the effective amount. For a nonzero effective amount, the carry-out is bit 31 of the result. This holds for multiples of 32 too, where the result equals the operand.
- R10: When `srcIsPc` is 1, the operand is taken as `operandIn` + 4 (modulo 2^32) before any shift.
- R11: The result and the carry are registered and appear one rising clock edge after the inputs. While `rstN` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| operandIn | input | 32 | Value to be shifted |
| srcIsPc | input | 1 | Operand is the program counter; add 4 |
| amountReg | input | 32 | Register supplying the shift amount |
| shiftKind | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| carryIn | input | 1 | Current carry flag |
| resultOut | output | 32 | Shifted operand, registered |
| carryOut | output | 1 | Carry-out flag, registered |

## Verification
Both outputs are due exactly one rising edge after the inputs are applied, because a single register stage sits between the inputs and the ports. The bench drives each new stimulus at a falling edge and pushes the reference model's answer into a queue. At the next falling edge, one edge after capture, it pops that answer and compares it with the ports. It never samples at the active edge, so each comparison lines up with the stimulus that produced it, and this holds across back-to-back changes of kind and amount.

// File: rtl/barrel_shift_pkg.sv
package barrel_shift_pkg;
  typedef enum logic [1:0] {
    KIND_LSL = 2'b00,
    KIND_LSR = 2'b01,
    KIND_ASR = 2'b10,
    KIND_ROR = 2'b11
  } shift_kind_e;

  localparam int unsigned MAX_SH_W = 8;

  typedef struct packed {
    logic                passThru;  // effective amount is zero
    logic                inRange;   // 1 .. width-1
    logic                atWidth;   // exactly the width
    logic                addPc;     // operand adjust strobe
    shift_kind_e         kind;
    logic [MAX_SH_W-1:0] amtLow;    // amount modulo width
  } shift_ctrl_t;
endpackage

// File: rtl/barrel_shift_ctrl.sv
module barrel_shift_ctrl
  import barrel_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [DATA_W-1:0] amountReg,
  input  logic [1:0]        shiftKind,
  input  logic              srcIsPc,
  output shift_ctrl_t       ctrl
);
  localparam int unsigned SH_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] AMT_MASK = DATA_W'((64'd1 << AMT_W) - 64'd1);

  logic [DATA_W-1:0] amtEff;

  always_comb begin
    amtEff        = amountReg & AMT_MASK;
    ctrl          = '0;
    ctrl.passThru = (amtEff == '0);
    ctrl.inRange  = (amtEff != '0) && (amtEff < DATA_W);
    ctrl.atWidth  = (amtEff == DATA_W);
    ctrl.addPc    = srcIsPc;
    ctrl.kind     = shift_kind_e'(shiftKind);
    ctrl.amtLow[SH_W-1:0] = amtEff[SH_W-1:0];
  end
endmodule

// File: rtl/barrel_shift_dp.sv
module barrel_shift_dp
  import barrel_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] operandIn,
  input  logic              carryIn,
  input  shift_ctrl_t       ctrl,
  output logic [DATA_W-1:0] shiftRes,
  output logic              shiftCarry
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0]        opv;
  logic [SH_W-1:0]          amt;
  logic [DATA_W:0]          lslWide;
  logic [DATA_W:0]          lsrWide;
  logic signed [DATA_W:0]   asrSrc;
  logic signed [DATA_W:0]   asrWide;
  logic [DATA_W-1:0]        rotVal;

  always_comb begin
    opv     = ctrl.addPc ? operandIn + DATA_W'(4) : operandIn;
    amt     = ctrl.amtLow[SH_W-1:0];
    lslWide = {1'b0, opv} << amt;
    lsrWide = {opv, 1'b0} >> amt;
    asrSrc  = {opv, 1'b0};
    asrWide = asrSrc >>> amt;
    rotVal  = (opv >> amt) | (opv << ((SH_W+1)'(DATA_W) - {1'b0, amt}));

    shiftRes   = opv;
    shiftCarry = carryIn;
    if (!ctrl.passThru) begin
      unique case (ctrl.kind)
        KIND_LSL: begin
          shiftRes   = ctrl.inRange ? lslWide[DATA_W-1:0] : '0;
          shiftCarry = ctrl.inRange ? lslWide[DATA_W] : (ctrl.atWidth & opv[0]);
        end
        KIND_LSR: begin
          shiftRes   = ctrl.inRange ? lsrWide[DATA_W:1] : '0;
          shiftCarry = ctrl.inRange ? lsrWide[0] : (ctrl.atWidth & opv[DATA_W-1]);
        end
        KIND_ASR: begin
          shiftRes   = ctrl.inRange ? asrWide[DATA_W:1] : {DATA_W{opv[DATA_W-1]}};
          shiftCarry = ctrl.inRange ? asrWide[0] : opv[DATA_W-1];
        end
        default: begin
          shiftRes   = rotVal;
          shiftCarry = rotVal[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/barrel_shift_top.sv
module barrel_shift_top
  import barrel_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] operandIn,
  input  logic              srcIsPc,
  input  logic [DATA_W-1:0] amountReg,
  input  logic [1:0]        shiftKind,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut
);
  shift_ctrl_t       ctrl;
  logic [DATA_W-1:0] shiftRes;
  logic              shiftCarry;

  barrel_shift_ctrl #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_ctrl (
    .amountReg (amountReg),
    .shiftKind (shiftKind),
    .srcIsPc   (srcIsPc),
    .ctrl      (ctrl)
  );

  barrel_shift_dp #(.DATA_W(DATA_W)) i_dp (
    .operandIn  (operandIn),
    .carryIn    (carryIn),
    .ctrl       (ctrl),
    .shiftRes   (shiftRes),
    .shiftCarry (shiftCarry)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut <= '0;
      carryOut  <= 1'b0;
    end else begin
      resultOut <= shiftRes;
      carryOut  <= shiftCarry;
    end
  end
endmodule

// File: rtl/barrel_shift_chk.sv
module barrel_shift_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] operandIn,
  input logic              srcIsPc,
  input logic [DATA_W-1:0] amountReg,
  input logic [1:0]        shiftKind,
  input logic              carryIn,
  input logic [DATA_W-1:0] resultOut,
  input logic              carryOut
);
  logic primed;
  logic [DATA_W-1:0] opAdj;
  logic [7:0]        amtByte;

  always_ff @(posedge clk) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  assign opAdj   = srcIsPc ? operandIn + DATA_W'(4) : operandIn;
  assign amtByte = amountReg[7:0];

  // R11
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |=> (resultOut == '0 && carryOut == 1'b0));

  // R2
  zero_amount_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && amtByte == 8'd0) |=>
      (resultOut == $past(opAdj) && carryOut == $past(carryIn)));

  // R4
  lsl_over_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && shiftKind == 2'b00 && amtByte > 8'd32) |=>
      (resultOut == '0 && carryOut == 1'b0));

  // R6
  lsr_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && shiftKind == 2'b01 && amtByte == 8'd32) |=>
      (resultOut == '0 && carryOut == $past(opAdj[DATA_W-1])));

  // R8
  asr_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && shiftKind == 2'b10 && amtByte >= 8'd32) |=>
      ($countones(resultOut) == ($past(opAdj[DATA_W-1]) ? DATA_W : 0)
       && carryOut == $past(opAdj[DATA_W-1])));

  // R9
  ror_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && shiftKind == 2'b11 && amtByte != 8'd0) |=>
      (carryOut == resultOut[DATA_W-1]));
endmodule

bind barrel_shift_top barrel_shift_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .operandIn (operandIn),
  .srcIsPc   (srcIsPc),
  .amountReg (amountReg),
  .shiftKind (shiftKind),
  .carryIn   (carryIn),
  .resultOut (resultOut),
  .carryOut  (carryOut)
);

// File: tb/test_barrel_shift_top.sv
module test_barrel_shift_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] operandIn = '0;
  logic        srcIsPc = 1'b0;
  logic [31:0] amountReg = '0;
  logic [1:0]  shiftKind = '0;
  logic        carryIn = 1'b0;
  logic [31:0] resultOut;
  logic        carryOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [32:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  barrel_shift_top i_barrel_shift_top (
    .clk(clk), .rstN(rstN), .operandIn(operandIn), .srcIsPc(srcIsPc),
    .amountReg(amountReg), .shiftKind(shiftKind), .carryIn(carryIn),
    .resultOut(resultOut), .carryOut(carryOut)
  );

  function automatic logic [32:0] refModel(input logic [31:0] op, input bit pc,
      input logic [31:0] areg, input logic [1:0] kind, input bit cin);
    logic [31:0] v;
    logic [31:0] res;
    bit c;
    int a, r;
    v = pc ? op + 32'd4 : op;
    a = int'(areg & 32'hFF);
    res = v; c = cin;
    if (a != 0) begin
      case (kind)
        2'b00: if (a < 32) begin res = v << a; c = v[32-a]; end
               else begin res = 0; c = (a == 32) ? v[0] : 1'b0; end
        2'b01: if (a < 32) begin res = v >> a; c = v[a-1]; end
               else begin res = 0; c = (a == 32) ? v[31] : 1'b0; end
        2'b10: if (a < 32) begin res = 32'($signed(v) >>> a); c = v[a-1]; end
               else begin res = {32{v[31]}}; c = v[31]; end
        default: begin
          r = a % 32;
          res = (r == 0) ? v : ((v >> r) | (v << (32 - r)));
          c = res[31];
        end
      endcase
    end
    return {c, res};
  endfunction

  function automatic string tagFor(input logic [31:0] areg, input logic [1:0] kind, input bit pc);
    int a;
    a = int'(areg & 32'hFF);
    if (pc) return "R10";
    if (areg[31:8] != 0) return "R1";
    if (a == 0) return "R2";
    case (kind)
      2'b00: return (a < 32) ? "R3" : "R4";
      2'b01: return (a < 32) ? "R5" : "R6";
      2'b10: return (a < 32) ? "R7" : "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [31:0] op, input bit pc, input logic [31:0] areg,
                       input logic [1:0] kind, input bit cin);
    @(negedge clk);
    if (expQ.size() != 0) begin
      logic [32:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({carryOut, resultOut} !== e) begin
        errors++;
        $display("FAIL %s: got res=%h c=%b expected res=%h c=%b", t,
                 resultOut, carryOut, e[31:0], e[32]);
      end
    end
    operandIn = op; srcIsPc = pc; amountReg = areg; shiftKind = kind; carryIn = cin;
    expQ.push_back(refModel(op, pc, areg, kind, cin));
    tagQ.push_back(tagFor(areg, kind, pc));
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11: watchdog expired got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    operandIn = 32'hDEAD_BEEF; amountReg = 32'd5; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    // R11: outputs held at zero in reset
    checks++;
    if (resultOut !== 32'd0 || carryOut !== 1'b0) begin
      errors++;
      $display("FAIL R11: got res=%h c=%b expected res=0 c=0", resultOut, carryOut);
    end
    rstN = 1'b1;
    begin
      logic [31:0] pats[4];
      pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
      pats[2] = 32'hA5C3_0F96; pats[3] = 32'h0000_0000;
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 4; k++)
          for (int a = 0; a < 256; a++)
            apply(pats[p], 1'b0, 32'(a), 2'(k), bit'((a + p) & 1));
    end
    // R1: upper amount bits ignored
    for (int k = 0; k < 4; k++) begin
      apply(32'h1234_5678, 1'b0, 32'hFFFF_FF00, 2'(k), 1'b1);
      apply(32'h1234_5678, 1'b0, 32'h0001_0020, 2'(k), 1'b0);
      apply(32'h8765_4321, 1'b0, 32'hABCD_0107, 2'(k), 1'b0);
    end
    // R10: program-counter operand adjust, including wrap
    for (int k = 0; k < 4; k++) begin
      apply(32'h0000_1000, 1'b1, 32'd0, 2'(k), 1'b1);
      apply(32'hFFFF_FFFE, 1'b1, 32'd1, 2'(k), 1'b0);
      apply(32'h7FFF_FFFC, 1'b1, 32'd32, 2'(k), 1'b0);
    end
    apply(32'h0, 1'b0, 32'd0, 2'b00, 1'b0);
    @(negedge clk);
    while (expQ.size() > 1) void'(expQ.pop_front());
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule